// File: doc/BRIEF.md
# Completion Status Register with Host Interrupt

This block is a small register file that sits between an embedded scheduler processor and a host. When the processor finishes a command-queue slot it sets the bit for that slot index in one of several status words; the host later reads the words to learn which slots are done. Each host read of a status word hands back the accumulated bits and clears that word in the same cycle, so every completion is reported exactly once.

A level interrupt tells the host that completions are waiting. It is active while the processor has turned on the interrupt-enable bit and at least one status bit is set. The processor has a one-cycle write port. The host has a read port whose data is registered and valid in the cycle after the read strobe. With the default parameters there are four 32-bit words (128 slot bits) at byte offsets 0x0, 0x4, 0x8 and 0xC, and the enable register sits at byte offset 0x100.

Top module: `completion_status_regs`

## Requirements
- R1: While `rst_n` is low, every status bit, the interrupt enable, `host_irq` and `host_rd_data` are zero.
- R2: A processor write to status word k (byte offset 4*k) ORs `proc_wr_data` into word k at the next clock edge. Bits set earlier are kept, and other words do not change.
- R3: A host read of status word k puts the word's current value on `host_rd_data` after the next clock edge and clears word k at that same edge.
- R4: When a processor write and a host read hit the same status word in the same cycle, the read returns the value from before the write. Afterwards the word holds exactly the newly written bits.
- R5: A processor write to byte offset 0x100 loads the interrupt enable from `proc_wr_data[0]`. A host read of 0x100 returns the enable in bit 0 with all other bits zero, and does not change the enable.
- R6: With the default `IRQ_REG=0`, `host_irq` is high exactly when the enable is 1 and any status bit is set. It follows register updates in the same cycle as they take effect.
- R7: Processor writes to offsets that map neither to a status word nor to the enable have no effect. Host reads of such offsets return zero and clear nothing.
- R8: Address bits [1:0] are ignored on both ports, so every byte address inside a word selects that word.
- R9: `host_rd_data` keeps its value in every cycle where `host_rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| proc_wr_en | input | 1 | Processor write strobe, one cycle per write |
| proc_wr_addr | input | ADDR_W (9) | Processor byte address |
| proc_wr_data | input | DATA_W (32) | Processor write data, a bitmask of completed slots or the enable in bit 0 |
| host_rd_en | input | 1 | Host read strobe, one cycle per read |
| host_rd_addr | input | ADDR_W (9) | Host byte address |
| host_rd_data | output | DATA_W (32) | Registered read data, valid the cycle after the strobe |
| host_irq | output | 1 | Level interrupt to the host |

## Verification
A status bit that is lost, stuck or set in the wrong place shows up on `host_rd_data` in the cycle after the host reads that word. A clear that fails to happen shows up on the second read of the same word. A wrong enable or a wrong status bit shows on `host_irq` in the same cycle the register changes. The bench therefore walks every single slot bit through write, read and re-read. It also drives same-cycle collisions, unmapped offsets and misaligned addresses, and checks the interrupt at each step.

// File: rtl/csr_status_pkg.sv
package csr_status_pkg;
   // Kind of register that a byte address selects
   typedef enum logic [1:0] {
      SEL_NONE   = 2'd0,
      SEL_STATUS = 2'd1,
      SEL_ENABLE = 2'd2
   } sel_kind_e;
endpackage

// File: rtl/csr_addr_dec.sv
module csr_addr_dec
   import csr_status_pkg::*;
#(
   parameter int ADDR_W    = 9,
   parameter int NUM_WORDS = 4,
   parameter int EN_OFS    = 256,
   parameter int IDX_W     = 2
) (
   input  logic [ADDR_W-1:0] addr,
   output sel_kind_e         kind,
   output logic [IDX_W-1:0]  idx
);
   localparam int WORD_LIM = NUM_WORDS;
   localparam int EN_WORD  = EN_OFS / 4;

   logic [ADDR_W-1:0] word_no;

   // Byte lane bits are dropped: the word number alone selects a register
   assign word_no = addr >> 2;
   assign idx     = IDX_W'(word_no);

   always_comb begin
      if (word_no < ADDR_W'(WORD_LIM))
         kind = SEL_STATUS;
      else if (word_no == ADDR_W'(EN_WORD))
         kind = SEL_ENABLE;
      else
         kind = SEL_NONE;
   end
endmodule

// File: rtl/csr_status_word.sv
module csr_status_word #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_en,
   input  logic [DATA_W-1:0] set_bits,
   input  logic              clr_en,
   output logic [DATA_W-1:0] word_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         word_q <= '0;
      else if (clr_en)
         // Read clears old content, a colliding write survives
         word_q <= set_en ? set_bits : '0;
      else if (set_en)
         word_q <= word_q | set_bits;
   end
endmodule

// File: rtl/csr_irq_gen.sv
module csr_irq_gen #(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic irq_en,
   input  logic any_set,
   output logic irq
);
   generate
      if (IRQ_REG) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               irq_q <= 1'b0;
            else
               irq_q <= irq_en & any_set;
         end
         assign irq = irq_q;
      end else begin : g_comb
         assign irq = irq_en & any_set;
      end
   endgenerate
endmodule

// File: rtl/completion_status_regs.sv
module completion_status_regs
   import csr_status_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int NUM_WORDS = 4,
   parameter int ADDR_W    = 9,
   parameter int EN_OFS    = 256,
   parameter bit IRQ_REG   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              proc_wr_en,
   input  logic [ADDR_W-1:0] proc_wr_addr,
   input  logic [DATA_W-1:0] proc_wr_data,
   input  logic              host_rd_en,
   input  logic [ADDR_W-1:0] host_rd_addr,
   output logic [DATA_W-1:0] host_rd_data,
   output logic              host_irq
);
   localparam int IDX_W  = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
   localparam int FLAT_W = NUM_WORDS * DATA_W;

   // Elaboration-time parameter checks
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be at least 1");
      end
      if (NUM_WORDS < 1) begin : g_bad_words
         $error("NUM_WORDS must be at least 1");
      end
      if (EN_OFS % 4 != 0 || EN_OFS < NUM_WORDS * 4) begin : g_bad_en
         $error("EN_OFS must be word aligned and above the status words");
      end
      if (EN_OFS >= (1 << ADDR_W)) begin : g_bad_addr
         $error("ADDR_W too small for EN_OFS");
      end
   endgenerate

   sel_kind_e        wr_kind, rd_kind;
   logic [IDX_W-1:0] wr_idx, rd_idx;
   logic             en_q;
   logic [FLAT_W-1:0] status_flat;
   logic [DATA_W-1:0] word_q [NUM_WORDS];
   logic [DATA_W-1:0] rd_mux;
   logic [DATA_W-1:0] rd_data_q;

   csr_addr_dec #(
      .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .EN_OFS(EN_OFS), .IDX_W(IDX_W)
   ) u_wr_dec (
      .addr(proc_wr_addr), .kind(wr_kind), .idx(wr_idx)
   );

   csr_addr_dec #(
      .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .EN_OFS(EN_OFS), .IDX_W(IDX_W)
   ) u_rd_dec (
      .addr(host_rd_addr), .kind(rd_kind), .idx(rd_idx)
   );

   genvar gi;
   generate
      for (gi = 0; gi < NUM_WORDS; gi++) begin : g_word
         logic hit_wr, hit_rd;
         assign hit_wr = proc_wr_en && (wr_kind == SEL_STATUS) &&
                         (wr_idx == IDX_W'(gi));
         assign hit_rd = host_rd_en && (rd_kind == SEL_STATUS) &&
                         (rd_idx == IDX_W'(gi));
         csr_status_word #(.DATA_W(DATA_W)) u_word (
            .clk(clk), .rst_n(rst_n),
            .set_en(hit_wr), .set_bits(proc_wr_data),
            .clr_en(hit_rd), .word_q(word_q[gi])
         );
         assign status_flat[gi*DATA_W +: DATA_W] = word_q[gi];
      end
   endgenerate

   // Enable register, written by the processor only
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         en_q <= 1'b0;
      else if (proc_wr_en && wr_kind == SEL_ENABLE)
         en_q <= proc_wr_data[0];
   end

   always_comb begin
      rd_mux = '0;
      if (rd_kind == SEL_STATUS)
         rd_mux = word_q[rd_idx];
      else if (rd_kind == SEL_ENABLE)
         rd_mux = DATA_W'(en_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_data_q <= '0;
      else if (host_rd_en)
         rd_data_q <= rd_mux;
   end

   assign host_rd_data = rd_data_q;

   csr_irq_gen #(.IRQ_REG(IRQ_REG)) u_irq (
      .clk(clk), .rst_n(rst_n),
      .irq_en(en_q), .any_set(|status_flat),
      .irq(host_irq)
   );
endmodule

// File: rtl/csr_status_chk.sv
module csr_status_chk #(
   parameter int DATA_W    = 32,
   parameter int NUM_WORDS = 4,
   parameter int ADDR_W    = 9,
   parameter bit IRQ_REG   = 1'b0
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        proc_wr_en,
   input logic [ADDR_W-1:0]           proc_wr_addr,
   input logic [DATA_W-1:0]           proc_wr_data,
   input logic                        host_rd_en,
   input logic [ADDR_W-1:0]           host_rd_addr,
   input logic [DATA_W-1:0]           host_rd_data,
   input logic                        host_irq,
   input logic [NUM_WORDS*DATA_W-1:0] status_flat
);
   logic [ADDR_W-1:0] wr_w, rd_w;
   logic wr_hit, rd_hit;

   assign wr_w   = proc_wr_addr >> 2;
   assign rd_w   = host_rd_addr >> 2;
   assign wr_hit = proc_wr_en && (wr_w < ADDR_W'(NUM_WORDS));
   assign rd_hit = host_rd_en && (rd_w < ADDR_W'(NUM_WORDS));

   function automatic logic [DATA_W-1:0] word_of(
      input logic [NUM_WORDS*DATA_W-1:0] flat, input logic [ADDR_W-1:0] w);
      return DATA_W'(flat >> (w * DATA_W));
   endfunction

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> (status_flat == '0 && host_rd_data == '0 && !host_irq));

   // R2
   no_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> ((word_of(status_flat, $past(wr_w)) & $past(proc_wr_data))
                  == $past(proc_wr_data)));

   // R3
   read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit && !(wr_hit && wr_w == rd_w))
      |=> (word_of(status_flat, $past(rd_w)) == '0));

   // R4
   collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit && wr_hit && wr_w == rd_w)
      |=> (word_of(status_flat, $past(rd_w)) == $past(proc_wr_data)));

   // R9
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !host_rd_en |=> $stable(host_rd_data));

   generate
      if (!IRQ_REG) begin : g_irq_chk
         // R6
         irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(host_irq) |-> $past(proc_wr_en));
         // R6
         irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(host_irq) |-> $past(host_rd_en || proc_wr_en));
      end
   endgenerate
endmodule

bind completion_status_regs csr_status_chk #(
   .DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W), .IRQ_REG(IRQ_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .proc_wr_en(proc_wr_en), .proc_wr_addr(proc_wr_addr),
   .proc_wr_data(proc_wr_data),
   .host_rd_en(host_rd_en), .host_rd_addr(host_rd_addr),
   .host_rd_data(host_rd_data), .host_irq(host_irq),
   .status_flat(status_flat)
);

// File: tb/completion_status_regs_tb.sv
`timescale 1ns/1ps
module completion_status_regs_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        proc_wr_en = 1'b0;
   logic [8:0]  proc_wr_addr = '0;
   logic [31:0] proc_wr_data = '0;
   logic        host_rd_en = 1'b0;
   logic [8:0]  host_rd_addr = '0;
   logic [31:0] host_rd_data;
   logic        host_irq;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   completion_status_regs u_dut (
      .clk(clk), .rst_n(rst_n),
      .proc_wr_en(proc_wr_en), .proc_wr_addr(proc_wr_addr),
      .proc_wr_data(proc_wr_data),
      .host_rd_en(host_rd_en), .host_rd_addr(host_rd_addr),
      .host_rd_data(host_rd_data), .host_irq(host_irq)
   );

   task automatic chk(input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // One clock: drive at a falling edge, return at the next falling edge
   task automatic cyc(input logic we, input logic [8:0] wa,
                      input logic [31:0] wd, input logic re,
                      input logic [8:0] ra);
      proc_wr_en = we; proc_wr_addr = wa; proc_wr_data = wd;
      host_rd_en = re; host_rd_addr = ra;
      @(negedge clk);
      proc_wr_en = 1'b0; host_rd_en = 1'b0;
   endtask

   task automatic wr(input logic [8:0] a, input logic [31:0] d);
      cyc(1'b1, a, d, 1'b0, '0);
   endtask

   task automatic rd(input logic [8:0] a);
      cyc(1'b0, '0, '0, 1'b1, a);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] hold;
      repeat (3) @(negedge clk);
      // R1: outputs at reset
      chk("R1 rd_data", host_rd_data, 32'h0);
      chk("R1 irq", {31'b0, host_irq}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int k = 0; k < 4; k++) begin
         rd(9'(4 * k));
         chk("R1 word", host_rd_data, 32'h0);
      end
      rd(9'h100);
      chk("R1 enable", host_rd_data, 32'h0);

      // R2/R3: walk every slot bit; enable is off so irq must stay low (R6)
      for (int k = 0; k < 4; k++) begin
         for (int b = 0; b < 32; b++) begin
            wr(9'(4 * k), 32'h1 << b);
            chk("R6 irq gated off", {31'b0, host_irq}, 32'h0);
            rd(9'(4 * k));
            chk("R3 read value", host_rd_data, 32'h1 << b);
            rd(9'(4 * k));
            chk("R3 cleared", host_rd_data, 32'h0);
         end
      end

      // R2: accumulation, neighbours untouched
      wr(9'h8, 32'h0000_00A5);
      wr(9'h8, 32'h5A00_0000);
      rd(9'h4);
      chk("R2 neighbour", host_rd_data, 32'h0);
      rd(9'h8);
      chk("R2 accumulate", host_rd_data, 32'h5A00_00A5);

      // R5: enable write and non-destructive read
      wr(9'h100, 32'h1);
      rd(9'h100);
      chk("R5 enable read", host_rd_data, 32'h1);
      rd(9'h100);
      chk("R5 enable kept", host_rd_data, 32'h1);
      chk("R6 no status", {31'b0, host_irq}, 32'h0);

      // R6: irq follows status while enabled
      wr(9'h4, 32'h20);
      chk("R6 irq on", {31'b0, host_irq}, 32'h1);
      wr(9'hC, 32'h1);
      rd(9'h4);
      chk("R6 irq still on", {31'b0, host_irq}, 32'h1);
      rd(9'hC);
      chk("R6 irq off", {31'b0, host_irq}, 32'h0);

      // R4: collision on the same word
      wr(9'hC, 32'hF0);
      cyc(1'b1, 9'hC, 32'h0F, 1'b1, 9'hC);
      chk("R4 old value", host_rd_data, 32'hF0);
      chk("R6 irq after collide", {31'b0, host_irq}, 32'h1);
      rd(9'hC);
      chk("R4 new bits kept", host_rd_data, 32'h0F);

      // R7: unmapped offsets
      wr(9'h10, 32'hFFFF_FFFF);
      wr(9'h80, 32'hFFFF_FFFF);
      wr(9'h104, 32'h0);
      chk("R7 irq", {31'b0, host_irq}, 32'h0);
      rd(9'h100);
      chk("R7 enable intact", host_rd_data, 32'h1);
      for (int k = 0; k < 4; k++) begin
         rd(9'(4 * k));
         chk("R7 no write", host_rd_data, 32'h0);
      end
      wr(9'h0, 32'h1);
      rd(9'h44);
      chk("R7 unmapped read", host_rd_data, 32'h0);
      rd(9'h0);
      chk("R7 nothing cleared", host_rd_data, 32'h1);

      // R8: byte lane bits ignored
      wr(9'h9, 32'h3);
      rd(9'hB);
      chk("R8 misaligned", host_rd_data, 32'h3);

      // R9: data holds while idle
      wr(9'h4, 32'h77);
      rd(9'h4);
      hold = host_rd_data;
      cyc(1'b0, '0, '0, 1'b0, 9'h4);
      cyc(1'b0, '0, '0, 1'b0, 9'h0);
      chk("R9 hold", host_rd_data, hold);
      chk("R9 hold value", host_rd_data, 32'h77);

      // R5/R6: only bit 0 loads the enable
      wr(9'h0, 32'h2);
      chk("R6 enabled", {31'b0, host_irq}, 32'h1);
      wr(9'h100, 32'hFFFF_FFFE);
      chk("R5 bit0 clears", {31'b0, host_irq}, 32'h0);
      rd(9'h100);
      chk("R5 enable read 0", host_rd_data, 32'h0);
      rd(9'h0);
      chk("R3 final", host_rd_data, 32'h2);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule